// File: doc/BRIEF.md
# Chained Serial Control-Register Target

This block is the device-side end of a slow serial port through which a controller reads and writes a small set of control registers in each of several memory devices. All devices share the serial clock and a command line. Each device takes data in on its upstream data line and repeats it on its downstream data line to the next device. During the data packet of a read, the direction turns around: read data flows back up the chain toward the controller.

A transaction opens with a framing pattern on the command line, sampled on both clock edges. Four 16-bit packets follow, each sent most significant bit first and sampled on the falling clock edge. The first packet is a request carrying an opcode, a broadcast flag and a device number. The second packet carries a register address. A write then sends the data word, followed by an idle interval packet. A read sends the interval first, so the addressed device has time to fetch its register, and the data packet comes last, driven upstream. Each pad is modelled as a separate input, output and output enable. The whole block runs on the serial clock.

Top module: `sio_chain_target`

## Requirements
- R1: While `rst` is high at a falling edge of `clk`, then after that edge `sio0_oe` is 0 and `sio1_oe` is 1.
- R2: A transaction starts only when the command samples form 1,1,1,1,0,0,0,0 over four clock cycles, taking the rising-edge sample of each cycle before its falling-edge sample. Bit time 0 is the period that ends at the next falling edge. Bit k of the 64-bit stream is sampled from `sio0_in` at the falling edge that ends bit time k. Any other command pattern starts nothing.
- R3: The request word (stream bits 0..15, sent MSB first) holds the opcode in [11:8], the broadcast flag in bit 7 and the device number in [5:0]. Bits [15:12] and bit 6 are zero. Opcode 0001 is a write and 0010 is a read.
- R4: Outside the read turnaround window, `sio1_oe` is 1 and `sio1_out` equals `sio0_in` in the same bit time.
- R5: A write stores stream bits 32..47 into register `addr[3:0]`, where the address is the low 12 bits of stream bits 16..31. It does so when the broadcast flag is set or the device number equals `dev_id`, and only if `addr[11:4]` is zero.
- R6: A write to another device, a write with an out-of-range address, and any opcode other than write or read leave every register unchanged.
- R7: For a framed read, `sio0_oe` is 1 and `sio1_oe` is 0 in bit times 47 through 64. In every other bit time `sio0_oe` is 0.
- R8: A read that is not broadcast and whose device number equals `dev_id` drives `sio0_out` with 0 in bit time 47, data bits 15 down to 0 in bit times 48 to 63, and 0 in bit time 64.
- R9: During the window, a broadcast read or a read addressed to another device sets `sio0_out` equal to `sio1_in`.
- R10: An addressed read of an address with a nonzero `addr[11:4]` returns the data word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; packet bits are taken on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | 6 | Strapped device number |
| cmd | input | 1 | Shared command line carrying the framing pattern |
| sio0_in | input | 1 | Upstream data line, input side |
| sio0_out | output | 1 | Upstream data line, output side (read data) |
| sio0_oe | output | 1 | Upstream line output enable |
| sio1_in | input | 1 | Downstream data line, input side (read data from further down) |
| sio1_out | output | 1 | Downstream data line, output side (repeated packets) |
| sio1_oe | output | 1 | Downstream line output enable |

## Verification
Two events meet in the same bit time at the turnaround: downstream repetition stops, and the upstream line starts driving, either with the device's own lead zero or with the pass-through of `sio1_in`. A handover that is one bit early or late breaks the chain. Reads are issued with random `sio1_in` values in every bit time, both as addressed reads and as non-addressed or broadcast reads. In each bit time the bench checks that exactly one enable is active, and that the upstream value is the model's data bit or the current `sio1_in` value. A register write and a fetch for a later read can also touch the same entry. Each write is therefore followed by reads of that entry, which are compared with a bench-side register model.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int PKT_W = 16;
  localparam int PKTS_PER_TXN = 4;
  localparam int OP_LSB  = 8;
  localparam int OP_W    = 4;
  localparam int BC_BIT  = 7;
  localparam int DEV_LSB = 0;
  localparam logic [OP_W-1:0] OP_WRITE = 4'b0001;
  localparam logic [OP_W-1:0] OP_READ  = 4'b0010;
  localparam logic [7:0] FRAME_PAT = 8'b1111_0000;
endpackage

// File: rtl/sio_frame_det.sv
module sio_frame_det
  import sio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  output logic frame_hit
);
  logic       cmd_rise;
  logic [5:0] hist;

  always_ff @(posedge clk) begin
    if (rst) cmd_rise <= 1'b0;
    else     cmd_rise <= cmd;
  end

  always_ff @(negedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[3:0], cmd_rise, cmd};
  end

  assign frame_hit = ({hist, cmd_rise, cmd} == FRAME_PAT);
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(negedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sio_chain_target.sv
module sio_chain_target
  import sio_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int ADDR_W = 12,
  parameter int DEV_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEV_W-1:0] dev_id,
  input  logic             cmd,
  input  logic             sio0_in,
  output logic             sio0_out,
  output logic             sio0_oe,
  input  logic             sio1_in,
  output logic             sio1_out,
  output logic             sio1_oe
);
  localparam int IDX_W = $clog2(NREGS);
  localparam int CNT_W = $clog2(PKT_W * PKTS_PER_TXN) + 1;
  localparam logic [CNT_W-1:0] B_REQ  = CNT_W'(PKT_W - 1);
  localparam logic [CNT_W-1:0] B_ADR  = CNT_W'(2 * PKT_W - 1);
  localparam logic [CNT_W-1:0] B_DAT  = CNT_W'(3 * PKT_W - 1);
  localparam logic [CNT_W-1:0] B_LEAD = CNT_W'(3 * PKT_W - 2);
  localparam logic [CNT_W-1:0] B_LAST = CNT_W'(4 * PKT_W - 1);
  localparam logic [CNT_W-1:0] B_END  = CNT_W'(4 * PKT_W);

  logic             frame_hit;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [PKT_W-2:0] shreg;
  logic [PKT_W-1:0] sample;
  logic [OP_W-1:0]  op_q;
  logic             bc_q;
  logic [DEV_W-1:0] dev_q;
  logic [ADDR_W-1:0] addr_q;
  logic             win, own, drv;
  logic [PKT_W-1:0] dsh;
  logic [PKT_W-1:0] rdata;
  logic             in_range, dev_match, wr_sel, rd_sel, is_write, is_read, wr_en;
  logic [PKT_W-1:0] rd_word;

  sio_frame_det u_frame (
    .clk(clk), .rst(rst), .cmd(cmd), .frame_hit(frame_hit)
  );

  assign sample    = {shreg, sio0_in};
  assign in_range  = (addr_q < ADDR_W'(NREGS));
  assign dev_match = (dev_q == dev_id);
  assign is_write  = (op_q == OP_WRITE);
  assign is_read   = (op_q == OP_READ);
  assign wr_sel    = bc_q || dev_match;
  assign rd_sel    = !bc_q && dev_match;
  assign wr_en     = active && !frame_hit && (cnt == B_DAT) && is_write && wr_sel && in_range;
  assign rd_word   = in_range ? rdata : '0;

  sio_regfile #(.DEPTH(NREGS), .WIDTH(PKT_W), .AW(IDX_W)) u_regs (
    .clk   (clk),
    .we    (wr_en),
    .waddr (addr_q[IDX_W-1:0]),
    .wdata (sample),
    .raddr (addr_q[IDX_W-1:0]),
    .rdata (rdata)
  );

  always_ff @(negedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      op_q   <= '0;
      bc_q   <= 1'b0;
      dev_q  <= '0;
      addr_q <= '0;
      win    <= 1'b0;
      own    <= 1'b0;
      drv    <= 1'b0;
      dsh    <= '0;
    end else begin
      shreg <= sample[PKT_W-2:0];
      if (frame_hit) begin
        active <= 1'b1;
        cnt    <= '0;
        win    <= 1'b0;
        own    <= 1'b0;
        drv    <= 1'b0;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (cnt == B_REQ) begin
          op_q  <= sample[OP_LSB +: OP_W];
          bc_q  <= sample[BC_BIT];
          dev_q <= sample[DEV_LSB +: DEV_W];
        end
        if (cnt == B_ADR) addr_q <= sample[ADDR_W-1:0];
        if (cnt == B_LEAD && is_read) begin
          win <= 1'b1;
          own <= rd_sel;
          drv <= 1'b0;
          dsh <= rd_word;
        end
        if (win && cnt >= B_DAT && cnt < B_LAST) begin
          drv <= dsh[PKT_W-1];
          dsh <= {dsh[PKT_W-2:0], 1'b0};
        end
        if (cnt == B_LAST) drv <= 1'b0;
        if (cnt == B_END) begin
          active <= 1'b0;
          win    <= 1'b0;
          own    <= 1'b0;
        end
      end
    end
  end

  assign sio0_oe  = win;
  assign sio0_out = own ? drv : sio1_in;
  assign sio1_oe  = !win;
  assign sio1_out = win ? 1'b0 : sio0_in;
endmodule

// File: rtl/sio_chain_target_chk.sv
module sio_chain_target_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             sio0_in,
  input logic             sio0_out,
  input logic             sio0_oe,
  input logic             sio1_in,
  input logic             sio1_out,
  input logic             sio1_oe,
  input logic             own,
  input logic             frame_hit,
  input logic [CNT_W-1:0] cnt
);
  assert_reset_idle_R1: assert property (@(negedge clk)
    rst |=> (!sio0_oe && sio1_oe));

  assert_frame_restart_R2: assert property (@(negedge clk) disable iff (rst)
    frame_hit |=> (cnt == '0));

  assert_forward_R4: assert property (@(negedge clk) disable iff (rst)
    sio1_oe |-> (sio1_out == sio0_in));

  assert_window_len_R7: assert property (@(negedge clk) disable iff (rst)
    ($fell(sio0_oe) && !$past(frame_hit) && !$past(rst))
      |-> ($past(sio0_oe, 18) && !$past(sio0_oe, 19)));

  assert_lead_zero_R8: assert property (@(negedge clk) disable iff (rst)
    ($rose(sio0_oe) && own) |-> !sio0_out);

  assert_pass_through_R9: assert property (@(negedge clk) disable iff (rst)
    (sio0_oe && !own) |-> (sio0_out == sio1_in));
endmodule

bind sio_chain_target sio_chain_target_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sio0_in(sio0_in), .sio0_out(sio0_out), .sio0_oe(sio0_oe),
  .sio1_in(sio1_in), .sio1_out(sio1_out), .sio1_oe(sio1_oe), .own(own),
  .frame_hit(frame_hit), .cnt(cnt)
);

// File: tb/sio_chain_target_bench.sv
module sio_chain_target_bench;
  localparam logic [5:0] MY_ID = 6'd21;
  localparam logic [3:0] OPW = 4'b0001;
  localparam logic [3:0] OPR = 4'b0010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd = 1'b0;
  logic sio0_in = 1'b0;
  logic sio1_in = 1'b0;
  logic sio0_out, sio0_oe, sio1_out, sio1_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model [16];

  always #5 clk = ~clk;

  sio_chain_target u_sio_chain_target (
    .clk(clk), .rst(rst), .dev_id(MY_ID), .cmd(cmd),
    .sio0_in(sio0_in), .sio0_out(sio0_out), .sio0_oe(sio0_oe),
    .sio1_in(sio1_in), .sio1_out(sio1_out), .sio1_oe(sio1_oe)
  );

  task automatic chk(input bit ok, input string tag, input int k,
                     input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s bit %0d: got %b expected %b", tag, k, got, exp);
    end
  endtask

  function automatic bit wr_hits(input logic [3:0] op, input logic bc,
                                 input logic [5:0] dv, input logic [11:0] ad);
    return (op == OPW) && (bc || dv == MY_ID) && (ad < 12'd16);
  endfunction

  function automatic logic [15:0] exp_read(input logic [11:0] ad);
    return (ad < 12'd16) ? model[ad[3:0]] : 16'h0000;
  endfunction

  task automatic half_cycles(input logic cr, input logic cf);
    cmd = cr;
    @(posedge clk); #1;
    cmd = cf;
    @(negedge clk); #1;
  endtask

  task automatic run_txn(input logic [3:0] op, input logic bc, input logic [5:0] dv,
                         input logic [11:0] ad, input logic [15:0] dt,
                         input bit good, input string tag);
    logic [63:0] stream;
    logic [15:0] req;
    logic [15:0] exp_word;
    bit is_rd, addressed, win_e;
    logic d, s1, e;
    req = {4'b0000, op, bc, 1'b0, dv};
    if (op == OPR) stream = {req, 4'b0000, ad, 16'($urandom), 16'h0000};
    else           stream = {req, 4'b0000, ad, dt, 16'($urandom)};
    is_rd = good && (op == OPR);
    addressed = !bc && (dv == MY_ID);
    exp_word = exp_read(ad);
    for (int i = 0; i < 4; i++) begin
      if (good) half_cycles(i < 2, i < 2);
      else      half_cycles(i < 2, i == 0);
    end
    for (int k = 0; k < 66; k++) begin
      d  = (k < 64) ? stream[63-k] : 1'b0;
      s1 = 1'($urandom);
      cmd = 1'b0;
      sio0_in = d;
      sio1_in = s1;
      @(posedge clk); #1;
      win_e = is_rd && (k >= 47) && (k <= 64);
      chk((sio0_oe === win_e) && (sio1_oe === !win_e), good ? "R7" : "R2", k,
          {sio0_oe, sio1_oe}, {win_e, !win_e});
      if (!win_e) begin
        chk(sio1_out === d, "R4", k, {1'b0, sio1_out}, {1'b0, d});
      end else if (addressed) begin
        if (k == 47 || k == 64) begin
          chk(sio0_out === 1'b0, "R8", k, {1'b0, sio0_out}, 2'b00);
        end else begin
          e = exp_word[63-k];
          chk(sio0_out === e, (ad >= 12'd16) ? "R10" : tag, k, {1'b0, sio0_out}, {1'b0, e});
        end
      end else begin
        chk(sio0_out === s1, "R9", k, {1'b0, sio0_out}, {1'b0, s1});
      end
      @(negedge clk); #1;
    end
    if (good && wr_hits(op, bc, dv, ad)) model[ad[3:0]] = dt;
  endtask

  initial begin
    logic [3:0] op;
    logic bc;
    logic [5:0] dv;
    logic [11:0] ad;
    int r;
    void'($urandom(32'd4242));
    @(negedge clk); #1;
    @(negedge clk); #1;
    @(negedge clk); #1;
    @(posedge clk); #1;
    chk((sio0_oe === 1'b0) && (sio1_oe === 1'b1), "R1", -1, {sio0_oe, sio1_oe}, 2'b01);
    @(negedge clk); #1;
    rst = 1'b0;

    for (int i = 0; i < 16; i++)
      run_txn(OPW, 1'b1, MY_ID ^ 6'd7, 12'(i), 16'hA000 + 16'(i * 37), 1'b1, "R5");
    run_txn(OPR, 1'b0, MY_ID, 12'd5, 16'h0, 1'b1, "R5");
    run_txn(OPW, 1'b0, MY_ID, 12'd7, 16'h5A3C, 1'b1, "R5");
    run_txn(OPR, 1'b0, MY_ID, 12'd7, 16'h0, 1'b1, "R5");
    run_txn(OPW, 1'b0, MY_ID ^ 6'd1, 12'd7, 16'h1111, 1'b1, "R6");
    run_txn(OPR, 1'b0, MY_ID, 12'd7, 16'h0, 1'b1, "R6");
    run_txn(4'b0100, 1'b0, MY_ID, 12'd7, 16'h2222, 1'b1, "R6");
    run_txn(OPR, 1'b0, MY_ID, 12'd7, 16'h0, 1'b1, "R6");
    run_txn(OPW, 1'b0, MY_ID, 12'h107, 16'h3333, 1'b1, "R6");
    run_txn(OPR, 1'b0, MY_ID, 12'd7, 16'h0, 1'b1, "R6");
    run_txn(OPR, 1'b0, MY_ID, 12'h107, 16'h0, 1'b1, "R10");
    run_txn(OPW, 1'b0, MY_ID, 12'd2, 16'h4444, 1'b0, "R2");
    run_txn(OPR, 1'b0, MY_ID, 12'd2, 16'h0, 1'b0, "R2");
    run_txn(OPR, 1'b0, MY_ID, 12'd2, 16'h0, 1'b1, "R2");
    run_txn(OPR, 1'b1, MY_ID, 12'd3, 16'h0, 1'b1, "R9");
    run_txn(OPR, 1'b0, MY_ID ^ 6'd9, 12'd3, 16'h0, 1'b1, "R9");

    for (int t = 0; t < 60; t++) begin
      r = int'($urandom_range(0, 7));
      if (r < 3)      op = OPW;
      else if (r < 6) op = OPR;
      else            op = 4'($urandom_range(3, 15));
      bc = ($urandom_range(0, 4) == 0);
      dv = ($urandom_range(0, 1) == 0) ? MY_ID : (MY_ID ^ 6'($urandom_range(1, 63)));
      ad = ($urandom_range(0, 4) == 0) ? 12'($urandom) : 12'($urandom_range(0, 15));
      run_txn(op, bc, dv, ad, 16'($urandom), 1'b1, "R3");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule